// File: doc/BRIEF.md
# Pipelined Nonrestoring Floating-Point Divider

This block divides one reduced-precision floating-point value by another. Both operands and the result share one compact format: a sign bit, a biased exponent of `EXP_W` bits and a stored fraction of `FRAC_W` bits behind an implicit leading one. The quotient significand is built by an unrolled chain of nonrestoring add/subtract steps. Each step yields one quotient bit, most significant bit first. The divisor travels down the chain alongside the partial remainder. `BITS_PER_STAGE` sets how many steps run between pipeline registers. This trades clock rate against latency and register count.

Operands enter on a valid/ready stream and results leave on another. A transfer takes place on a clock edge where valid and ready are both high. The whole pipeline advances as one unit. It advances when the output holds nothing or when the consumer accepts the output. Otherwise every stage holds, the output stays stable, and `in_ready` is low. One operand pair can be accepted per cycle. Results leave in the order their operands arrived.

Denormal operands, infinities, NaNs and exponent overflow or underflow are outside the scope of this block. The one exception is a zero divisor, which raises a flag that travels with its result.

Top module: `fpdiv_nr`

## Requirements
- R1: Word layout: bit `W-1` is the sign, bits `W-2:FRAC_W` are the exponent biased by `2^(EXP_W-1)-1`, and bits `FRAC_W-1:0` are the fraction. The value is (-1)^sign · 2^(exp-bias) · (1 + frac/2^FRAC_W), where `W = 1+EXP_W+FRAC_W`.
- R2: The result sign is the XOR of the two operand signs, including for a zero divisor.
- R3: Let S1 and S2 be the significands with the hidden one, each `FRAC_W+1` bits wide. When S1 ≥ S2 the result exponent is E1−E2+bias. When S1 < S2 it is E1−E2+bias−1.
- R4: Let Q = floor(S1·2^(FRAC_W+1)/S2). When S1 ≥ S2 the result fraction is Q[FRAC_W:1]. Otherwise it is Q[FRAC_W−1:0]. This is the truncated quotient, and no rounding is applied.
- R5: A divisor whose exponent and fraction are both zero is a zero divisor. For such a divisor `out_dz` is high with its result, the exponent field is all ones and the fraction is zero. `out_dz` is never high while `out_valid` is low.
- R6: An accepted operand pair reaches the output after ceil((FRAC_W+2)/BITS_PER_STAGE) cycles in which the pipeline advances. With the default parameters this is 5 cycles when there is no back-pressure.
- R7: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. In that case the output word, `out_dz` and `out_valid` stay unchanged into the next cycle.
- R8: Every accepted pair yields exactly one result, in arrival order. No result appears without a matching input. At most as many pairs are in flight as there are pipeline stages.
- R9: While reset (`rst_n` low) is applied, `out_valid` and `out_dz` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block accepts an operand pair this cycle |
| in_a | input | W | Dividend |
| in_b | input | W | Divisor |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result this cycle |
| out_q | output | W | Quotient |
| out_dz | output | 1 | Result came from a zero divisor |

## Verification
The assertions assume that the consumer's `out_ready` and the producer's `in_valid` are ordinary synchronous signals, free of glitches, and driven only while reset is released. The in-flight bound assumes that the producer holds no item outside the handshake. The value checks assume that every non-zero operand has a non-zero exponent. They also assume that E1−E2+bias stays inside the exponent range. The stimulus draws exponents from a narrow central band so that neither overflow nor underflow can occur. The only zero-exponent divisors it applies are exact zeros.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

  // Direction of one nonrestoring step.
  typedef enum logic {NR_SUB = 1'b0, NR_ADD = 1'b1} nr_op_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/fpdiv_unpack.sv
module fpdiv_unpack #(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 15,
  parameter int SIG_W  = FRAC_W + 1,
  parameter int EXP_IW = EXP_W + 2
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  output logic [SIG_W-1:0]      sig_a,
  output logic [SIG_W-1:0]      sig_b,
  output logic                  sign,
  output logic [EXP_IW-1:0]     exp_raw,
  output logic                  dz
);
  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int BIAS = (2 ** (EXP_W - 1)) - 1;
  localparam logic [EXP_IW-1:0] BIAS_V = EXP_IW'(BIAS);

  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;

  assign ea = a[W-2:FRAC_W];
  assign eb = b[W-2:FRAC_W];
  assign fa = a[FRAC_W-1:0];
  assign fb = b[FRAC_W-1:0];

  assign sig_a   = {1'b1, fa};
  assign sig_b   = {1'b1, fb};
  assign sign    = a[W-1] ^ b[W-1];
  assign exp_raw = EXP_IW'(ea) - EXP_IW'(eb) + BIAS_V;
  assign dz      = (eb == '0) && (fb == '0);
endmodule

// File: rtl/fpdiv_stage.sv
module fpdiv_stage import fpdiv_pkg::*; #(
  parameter int SIG_W  = 16,
  parameter int REM_W  = 19,
  parameter int Q_W    = 17,
  parameter int EXP_IW = 9,
  parameter int STEPS  = 4,
  parameter bit FIRST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              in_valid,
  input  logic [REM_W-1:0]  in_rem,
  input  logic [SIG_W-1:0]  in_div,
  input  logic [Q_W-1:0]    in_q,
  input  logic              in_sign,
  input  logic [EXP_IW-1:0] in_exp,
  input  logic              in_dz,
  output logic              out_valid,
  output logic [REM_W-1:0]  out_rem,
  output logic [SIG_W-1:0]  out_div,
  output logic [Q_W-1:0]    out_q,
  output logic              out_sign,
  output logic [EXP_IW-1:0] out_exp,
  output logic              out_dz
);
  logic [REM_W-1:0] rem_c;
  logic [REM_W-1:0] dvs;
  logic [Q_W-1:0]   q_c;
  nr_op_e           op;

  assign dvs = REM_W'(in_div);

  always_comb begin
    rem_c = in_rem;
    q_c   = in_q;
    op    = NR_SUB;
    for (int i = 0; i < STEPS; i++) begin
      if (FIRST && (i == 0)) begin
        rem_c = rem_c - dvs;
      end else begin
        op    = rem_c[REM_W-1] ? NR_ADD : NR_SUB;
        rem_c = {rem_c[REM_W-2:0], 1'b0};
        rem_c = (op == NR_ADD) ? (rem_c + dvs) : (rem_c - dvs);
      end
      q_c = {q_c[Q_W-2:0], ~rem_c[REM_W-1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rem   <= '0;
      out_div   <= '0;
      out_q     <= '0;
      out_sign  <= 1'b0;
      out_exp   <= '0;
      out_dz    <= 1'b0;
    end else if (adv) begin
      out_valid <= in_valid;
      out_rem   <= rem_c;
      out_div   <= in_div;
      out_q     <= q_c;
      out_sign  <= in_sign;
      out_exp   <= in_exp;
      out_dz    <= in_dz;
    end
  end
endmodule

// File: rtl/fpdiv_norm.sv
module fpdiv_norm #(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 15,
  parameter int Q_W    = FRAC_W + 2,
  parameter int EXP_IW = EXP_W + 2
) (
  input  logic                  valid,
  input  logic [Q_W-1:0]        q,
  input  logic                  sign,
  input  logic [EXP_IW-1:0]     exp_raw,
  input  logic                  dz,
  output logic [EXP_W+FRAC_W:0] word,
  output logic                  dz_flag
);
  logic              msb;
  logic [FRAC_W-1:0] frac;
  logic [EXP_IW-1:0] exp_adj;

  assign msb     = q[Q_W-1];
  assign frac    = msb ? q[Q_W-2:1] : q[Q_W-3:0];
  assign exp_adj = exp_raw - EXP_IW'(!msb);

  always_comb begin
    if (dz) word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else    word = {sign, exp_adj[EXP_W-1:0], frac};
  end

  assign dz_flag = valid & dz;
endmodule

// File: rtl/fpdiv_nr.sv
module fpdiv_nr import fpdiv_pkg::*; #(
  parameter int EXP_W          = 7,
  parameter int FRAC_W         = 15,
  parameter int BITS_PER_STAGE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [EXP_W+FRAC_W:0] in_a,
  input  logic [EXP_W+FRAC_W:0] in_b,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [EXP_W+FRAC_W:0] out_q,
  output logic                  out_dz
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int NQ     = SIG_W + 1;
  localparam int NSTG   = ceil_div(NQ, BITS_PER_STAGE);
  localparam int REM_W  = SIG_W + 3;
  localparam int EXP_IW = EXP_W + 2;

  logic              v_a    [0:NSTG];
  logic [REM_W-1:0]  rem_a  [0:NSTG];
  logic [SIG_W-1:0]  div_a  [0:NSTG];
  logic [NQ-1:0]     q_a    [0:NSTG];
  logic              sign_a [0:NSTG];
  logic [EXP_IW-1:0] exp_a  [0:NSTG];
  logic              dz_a   [0:NSTG];
  logic [SIG_W-1:0]  sig_a;
  logic              adv;

  assign adv      = !v_a[NSTG] || out_ready;
  assign in_ready = adv;

  fpdiv_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SIG_W(SIG_W), .EXP_IW(EXP_IW)) u_unpack (
    .a(in_a), .b(in_b), .sig_a(sig_a), .sig_b(div_a[0]),
    .sign(sign_a[0]), .exp_raw(exp_a[0]), .dz(dz_a[0])
  );

  assign v_a[0]   = in_valid;
  assign rem_a[0] = REM_W'(sig_a);
  assign q_a[0]   = '0;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    localparam int STEPS = (g == NSTG - 1) ? (NQ - (NSTG - 1) * BITS_PER_STAGE) : BITS_PER_STAGE;
    fpdiv_stage #(
      .SIG_W(SIG_W), .REM_W(REM_W), .Q_W(NQ), .EXP_IW(EXP_IW),
      .STEPS(STEPS), .FIRST(g == 0)
    ) u_stage (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .in_valid(v_a[g]), .in_rem(rem_a[g]), .in_div(div_a[g]), .in_q(q_a[g]),
      .in_sign(sign_a[g]), .in_exp(exp_a[g]), .in_dz(dz_a[g]),
      .out_valid(v_a[g+1]), .out_rem(rem_a[g+1]), .out_div(div_a[g+1]), .out_q(q_a[g+1]),
      .out_sign(sign_a[g+1]), .out_exp(exp_a[g+1]), .out_dz(dz_a[g+1])
    );
  end

  fpdiv_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .Q_W(NQ), .EXP_IW(EXP_IW)) u_norm (
    .valid(v_a[NSTG]), .q(q_a[NSTG]), .sign(sign_a[NSTG]), .exp_raw(exp_a[NSTG]),
    .dz(dz_a[NSTG]), .word(out_q), .dz_flag(out_dz)
  );

  assign out_valid = v_a[NSTG];
endmodule

// File: rtl/fpdiv_nr_chk.sv
module fpdiv_nr_chk #(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 15,
  parameter int DEPTH  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [EXP_W+FRAC_W:0] out_q,
  input logic                  out_dz
);
  int inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= 0;
    else inflight <= inflight + ((in_valid && in_ready) ? 1 : 0) - ((out_valid && out_ready) ? 1 : 0);
  end

  // R7: output held while the consumer stalls
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_q) && $stable(out_dz)));

  // R7: input back-pressure only when the output is blocked
  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R5: zero-divisor flag only with a result, carrying the fixed pattern
  p_dz_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_dz |-> (out_valid && (out_q[EXP_W+FRAC_W-1:FRAC_W] == '1) && (out_q[FRAC_W-1:0] == '0)));

  // R8: no more in flight than pipeline stages
  p_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= DEPTH);

  // R8: no result without a matching accepted input
  p_no_phantom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight > 0));

  // R9: output empty on leaving reset
  p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !out_dz));
endmodule

bind fpdiv_nr fpdiv_nr_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DEPTH(NSTG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_q(out_q), .out_dz(out_dz)
);

// File: tb/fpdiv_nr_test.sv
module fpdiv_nr_test;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_W  = 7;
  localparam int FRAC_W = 15;
  localparam int BPS    = 4;
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int NSTG   = (FRAC_W + 2 + BPS - 1) / BPS;
  localparam int BIAS   = (2 ** (EXP_W - 1)) - 1;
  localparam int N_DIR  = 12;
  localparam int N_RAND = 600;
  localparam int N_ALL  = N_DIR + N_RAND;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_q;
  logic out_dz;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fpdiv_nr #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BITS_PER_STAGE(BPS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_q(out_q), .out_dz(out_dz)
  );

  // model slots: index NSTG-1 is the output
  logic         mv  [NSTG];
  logic [W-1:0] md  [NSTG];
  logic         mdz [NSTG];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] mk(input bit s, input int e, input int f);
    return {s, EXP_W'(e), FRAC_W'(f)};
  endfunction

  // expected {dz, word}, computed from R2..R5
  function automatic logic [W:0] ref_div(input logic [W-1:0] a, input logic [W-1:0] b);
    longint s1, s2, q, frac, e;
    bit sg;
    sg = a[W-1] ^ b[W-1];
    if (b[W-2:0] == '0) return {1'b1, sg, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    s1 = (longint'(1) << FRAC_W) + longint'(a[FRAC_W-1:0]);
    s2 = (longint'(1) << FRAC_W) + longint'(b[FRAC_W-1:0]);
    q  = (s1 << (FRAC_W + 1)) / s2;
    e  = longint'(a[W-2:FRAC_W]) - longint'(b[W-2:FRAC_W]) + BIAS;
    if (s1 >= s2) frac = q >> 1;
    else begin frac = q; e = e - 1; end
    return {1'b0, sg, EXP_W'(e), FRAC_W'(frac)};
  endfunction

  function automatic logic [W-1:0] dir_a(input int i);
    case (i)
      0: return mk(0, 63, 0);
      1: return mk(0, 63, 16384);
      2: return mk(0, 70, 0);
      3: return mk(0, 50, 32767);
      4: return mk(0, 80, 0);
      5: return mk(1, 64, 1000);
      6: return mk(1, 60, 20000);
      7: return mk(0, 66, 5);
      8: return mk(0, 63, 123);
      9: return mk(1, 70, 7);
      10: return mk(0, 55, 4660);
      default: return mk(1, 75, 30000);
    endcase
  endfunction

  function automatic logic [W-1:0] dir_b(input int i);
    case (i)
      0: return mk(0, 63, 0);
      1: return mk(0, 63, 0);
      2: return mk(0, 60, 16384);
      3: return mk(0, 60, 0);
      4: return mk(0, 50, 32767);
      5: return mk(0, 62, 3000);
      6: return mk(1, 61, 100);
      7: return mk(1, 66, 5);
      8: return mk(0, 0, 0);
      9: return mk(1, 0, 0);
      10: return mk(0, 55, 4660);
      default: return mk(0, 40, 0);
    endcase
  endfunction

  logic [W-1:0] cur_a, cur_b;
  int idx = 0;
  int pops = 0;
  int cyc = 0;

  initial begin
    for (int k = 0; k < NSTG; k++) begin mv[k] = 1'b0; md[k] = '0; mdz[k] = 1'b0; end
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
      chk(out_dz == 1'b0, "R9 out_dz in reset", out_dz, 0);
    end
    rst_n = 1'b1;
    cur_a = dir_a(0);
    cur_b = dir_b(0);
    while (idx < N_ALL || cyc < 4000) begin
      bit adv_m;
      logic [W:0] rv;
      @(negedge clk);
      cyc++;
      // outputs after the last edge
      chk(out_valid == mv[NSTG-1], "R6 R8 out_valid", out_valid, mv[NSTG-1]);
      chk(out_dz == (mv[NSTG-1] & mdz[NSTG-1]), "R5 out_dz", out_dz, mv[NSTG-1] & mdz[NSTG-1]);
      if (mv[NSTG-1] && out_valid) begin
        chk(out_q[W-1] == md[NSTG-1][W-1], "R2 sign", out_q[W-1], md[NSTG-1][W-1]);
        chk(out_q[W-2:FRAC_W] == md[NSTG-1][W-2:FRAC_W], "R3 exponent",
            out_q[W-2:FRAC_W], md[NSTG-1][W-2:FRAC_W]);
        chk(out_q[FRAC_W-1:0] == md[NSTG-1][FRAC_W-1:0], "R1 R4 fraction",
            out_q[FRAC_W-1:0], md[NSTG-1][FRAC_W-1:0]);
      end
      // new stimulus
      if (cyc < 150) out_ready = 1'b1;
      else if (cyc < 1200) out_ready = ($urandom_range(0, 9) < 7);
      else out_ready = ((cyc % 17) >= 6);
      if (idx < N_DIR) in_valid = 1'b1;
      else if (idx < N_ALL) in_valid = ($urandom_range(0, 9) < 8);
      else in_valid = 1'b0;
      in_a = cur_a;
      in_b = cur_b;
      #1;
      adv_m = !mv[NSTG-1] || out_ready;
      chk(in_ready == adv_m, "R7 in_ready", in_ready, adv_m);
      if (out_valid && out_ready) pops++;
      if (adv_m) begin
        for (int k = NSTG - 1; k > 0; k--) begin
          mv[k] = mv[k-1]; md[k] = md[k-1]; mdz[k] = mdz[k-1];
        end
        rv = ref_div(in_a, in_b);
        mv[0] = in_valid;
        md[0] = rv[W-1:0];
        mdz[0] = rv[W];
        if (in_valid) begin
          idx++;
          if (idx < N_DIR) begin
            cur_a = dir_a(idx);
            cur_b = dir_b(idx);
          end else begin
            cur_a = mk($urandom_range(0, 1), $urandom_range(40, 86), $urandom_range(0, 32767));
            if ($urandom_range(0, 15) == 0) cur_b = mk($urandom_range(0, 1), 0, 0);
            else cur_b = mk($urandom_range(0, 1), $urandom_range(40, 86), $urandom_range(0, 32767));
          end
        end
      end
    end
    // drain
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int d = 0; d < NSTG + 4; d++) begin
      @(negedge clk);
      chk(out_valid == mv[NSTG-1], "R8 drain valid", out_valid, mv[NSTG-1]);
      if (out_valid) pops++;
      for (int k = NSTG - 1; k > 0; k--) begin mv[k] = mv[k-1]; md[k] = md[k-1]; mdz[k] = mdz[k-1]; end
      mv[0] = 1'b0;
    end
    chk(pops == N_ALL, "R8 result count", pops, N_ALL);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", pops, N_ALL);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule